// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block turns a 32-bit virtual address and a context number into a final translation entry. It walks a page table held in memory. A request carries the address and the context. The walker first reads the context table entry that the context number selects. From there it follows pointer entries through up to three table levels. Level 1 has 256 entries indexed by VA[31:24]. Levels 2 and 3 have 64 entries each, indexed by VA[23:18] and VA[17:12]. Each memory read fetches one 32-bit word at `table base + 4 * index`.

The two low bits of every fetched word give its entry type, and that type decides the next step. A final entry ends the walk: at level 1 it maps 16 MB, at level 2 it maps 256 KB and at level 3 it maps 4 KB. The returned level code shows which size applies. Other types either descend to the next level or end the walk with a fault. A fault reports the level at which the walk stopped.

Table pointers are held in compressed form. Both the root register and pointer entries hold `physical >> 4` with the low nibble cleared. The walker rebuilds the 36-bit physical table address by shifting the masked value left by four bits.

Top module: `ptw_walker`

## Requirements
- R1: After reset, `req_ready` is 1, and `mem_rd_valid` and `rsp_valid` are 0.
- R2: The first read of a walk goes to `((root & 0xFFFFFFF0) << 4) + 4 * ctx`. Here `root` is the last value written through `cfg_root_we`, and its low four bits have no effect on any address.
- R3: A pointer entry (bits [1:0] = 1) read at level L (0 = context, 1, 2) leads to a read at level L+1. That read goes to `((word & 0xFFFFFFF0) << 4) + 4 * idx`, where idx is VA[31:24] for level 1, VA[23:18] for level 2 and VA[17:12] for level 3.
- R4: A final entry (bits [1:0] = 2) read at level 1, 2 or 3 ends the walk. The response carries that word, fault 0, and level code 1, 2 or 3 respectively.
- R5: An invalid entry (bits [1:0] = 0) at any level ends the walk. The response has fault 1, the word, and the level at which it was read.
- R6: A reserved entry (bits [1:0] = 3) at any level ends the walk. The response has fault 1 and the level at which it was read.
- R7: A pointer entry at level 3 faults with level code 3. A final entry in the context table faults with level code 0.
- R8: At most one read is outstanding. `mem_rd_valid` keeps its address stable until `mem_rd_ready` is seen. No new read is issued before the response to the previous read arrives.
- R9: `rsp_valid` and the response fields stay stable until `rsp_ready`. The cycle after the response is taken, the walker is idle with `req_ready` = 1.
- R10: While a walk is in progress `req_ready` is 0, and a request presented then has no effect on the walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_root_we | input | 1 | Write strobe for the context table root register |
| cfg_root_data | input | 32 | Root value, physical base shifted right by 4 |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Walker idle and accepting a request |
| req_vaddr | input | 32 | Virtual address to translate |
| req_ctx | input | 16 | Context number |
| mem_rd_valid | output | 1 | Memory read request valid |
| mem_rd_ready | input | 1 | Memory accepts the read request |
| mem_rd_addr | output | 36 | Physical byte address of the word to read |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_ready | output | 1 | Walker waiting for read data |
| mem_rsp_data | input | 32 | Read data word |
| rsp_valid | output | 1 | Walk result valid |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_entry | output | 32 | Final or offending entry word |
| rsp_level | output | 2 | Level code where the walk stopped (0 to 3) |
| rsp_fault | output | 1 | Walk ended in a fault |

## Verification
A corrupted level counter or table base appears on `mem_rd_addr` at the very next read of the walk. The bench compares every read address against an independently computed walk, so the wrong read is flagged in the same walk. A decode slip ends the walk too early or too late, or flips the fault flag. Either way, the read count, `rsp_level` or `rsp_fault` differs from the model when the response appears. Handshake or state errors show within a cycle as unstable outputs, a second outstanding read, or `req_ready` not returning after the response.

// File: rtl/walk_pkg.sv
package walk_pkg;
    localparam int WORD_W    = 32;
    localparam int PTR_SHIFT = 4;
    localparam int PA_W      = WORD_W + PTR_SHIFT;
    localparam int VA_W      = 32;

    // level index fields of the virtual address
    localparam int L1_SHIFT = 24;
    localparam int L1_BITS  = 8;
    localparam int L2_SHIFT = 18;
    localparam int L2_BITS  = 6;
    localparam int L3_SHIFT = 12;
    localparam int L3_BITS  = 6;

    localparam logic [PA_W-1:0] PTR_MASK = PA_W'(32'hFFFF_FFF0);

    typedef enum logic [1:0] {
        ET_INVALID  = 2'd0,
        ET_POINTER  = 2'd1,
        ET_LEAF     = 2'd2,
        ET_RESERVED = 2'd3
    } etype_e;

    typedef enum logic [1:0] {
        LV_CTX     = 2'd0,
        LV_REGION  = 2'd1,
        LV_SEGMENT = 2'd2,
        LV_PAGE    = 2'd3
    } level_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_WAIT,
        ST_RESP
    } wstate_e;

    typedef enum logic [1:0] {
        ACT_DESCEND,
        ACT_FINISH,
        ACT_FAULT
    } act_e;

    typedef struct packed {
        act_e            act;
        logic [PA_W-1:0] next_base;
    } decode_t;

    // rebuild a physical table address from its compressed form
    function automatic logic [PA_W-1:0] expand_ptr(input logic [WORD_W-1:0] w);
        return (PA_W'(w) & PTR_MASK) << PTR_SHIFT;
    endfunction
endpackage

// File: rtl/walk_index.sv
module walk_index
    import walk_pkg::*;
#(
    parameter int CTX_W = 16
) (
    input  level_e              level,
    input  logic [VA_W-1:0]     vaddr,
    input  logic [CTX_W-1:0]    ctx,
    input  logic [PA_W-1:0]     base,
    output logic [PA_W-1:0]     addr
);
    localparam logic [PA_W-1:0] L1_MASK = PA_W'((1 << L1_BITS) - 1);
    localparam logic [PA_W-1:0] L2_MASK = PA_W'((1 << L2_BITS) - 1);
    localparam logic [PA_W-1:0] L3_MASK = PA_W'((1 << L3_BITS) - 1);

    logic [PA_W-1:0] idx;

    always_comb begin
        unique case (level)
            LV_CTX:     idx = PA_W'(ctx);
            LV_REGION:  idx = PA_W'(vaddr >> L1_SHIFT) & L1_MASK;
            LV_SEGMENT: idx = PA_W'(vaddr >> L2_SHIFT) & L2_MASK;
            default:    idx = PA_W'(vaddr >> L3_SHIFT) & L3_MASK;
        endcase
        addr = base + (idx << 2);
    end
endmodule

// File: rtl/walk_decode.sv
module walk_decode
    import walk_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    input  level_e            level,
    output decode_t           dec
);
    etype_e et;

    always_comb begin
        et            = etype_e'(word[1:0]);
        dec.next_base = expand_ptr(word);
        unique case (et)
            ET_POINTER: dec.act = (level == LV_PAGE) ? ACT_FAULT : ACT_DESCEND;
            ET_LEAF:    dec.act = (level == LV_CTX)  ? ACT_FAULT : ACT_FINISH;
            default:    dec.act = ACT_FAULT;
        endcase
    end
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
    import walk_pkg::*;
#(
    parameter int CTX_W = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cfg_root_we,
    input  logic [WORD_W-1:0]   cfg_root_data,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic [VA_W-1:0]     req_vaddr,
    input  logic [CTX_W-1:0]    req_ctx,
    output logic                mem_rd_valid,
    input  logic                mem_rd_ready,
    output logic [PA_W-1:0]     mem_rd_addr,
    input  logic                mem_rsp_valid,
    output logic                mem_rsp_ready,
    input  logic [WORD_W-1:0]   mem_rsp_data,
    output logic                rsp_valid,
    input  logic                rsp_ready,
    output logic [WORD_W-1:0]   rsp_entry,
    output logic [1:0]          rsp_level,
    output logic                rsp_fault
);
    wstate_e           state;
    level_e            level_q;
    logic [PA_W-1:0]   tbase_q;
    logic [VA_W-1:0]   va_q;
    logic [CTX_W-1:0]  ctx_q;
    logic [WORD_W-1:0] root_q;
    logic [WORD_W-1:0] entry_q;
    logic              fault_q;
    decode_t           dec;

    walk_index #(.CTX_W(CTX_W)) u_index (
        .level (level_q),
        .vaddr (va_q),
        .ctx   (ctx_q),
        .base  (tbase_q),
        .addr  (mem_rd_addr)
    );

    walk_decode u_decode (
        .word  (mem_rsp_data),
        .level (level_q),
        .dec   (dec)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            root_q <= '0;
        end else if (cfg_root_we) begin
            root_q <= cfg_root_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            level_q <= LV_CTX;
            tbase_q <= '0;
            va_q    <= '0;
            ctx_q   <= '0;
            entry_q <= '0;
            fault_q <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: if (req_valid) begin
                    va_q    <= req_vaddr;
                    ctx_q   <= req_ctx;
                    level_q <= LV_CTX;
                    tbase_q <= expand_ptr(root_q);
                    state   <= ST_ISSUE;
                end
                ST_ISSUE: if (mem_rd_ready) begin
                    state <= ST_WAIT;
                end
                ST_WAIT: if (mem_rsp_valid) begin
                    unique case (dec.act)
                        ACT_DESCEND: begin
                            tbase_q <= dec.next_base;
                            level_q <= level_e'(level_q + 2'd1);
                            state   <= ST_ISSUE;
                        end
                        ACT_FINISH: begin
                            entry_q <= mem_rsp_data;
                            fault_q <= 1'b0;
                            state   <= ST_RESP;
                        end
                        default: begin
                            entry_q <= mem_rsp_data;
                            fault_q <= 1'b1;
                            state   <= ST_RESP;
                        end
                    endcase
                end
                default: if (rsp_ready) begin
                    state <= ST_IDLE;
                end
            endcase
        end
    end

    assign req_ready     = (state == ST_IDLE);
    assign mem_rd_valid  = (state == ST_ISSUE);
    assign mem_rsp_ready = (state == ST_WAIT);
    assign rsp_valid     = (state == ST_RESP);
    assign rsp_entry     = entry_q;
    assign rsp_level     = level_q;
    assign rsp_fault     = fault_q;

    // read request held with a stable address until accepted
    assert_rd_hold_R8: assert property (@(posedge clk) disable iff (rst)
        mem_rd_valid && !mem_rd_ready |=> mem_rd_valid && $stable(mem_rd_addr));

    // accepted read is never followed directly by another request
    assert_one_outstanding_R8: assert property (@(posedge clk) disable iff (rst)
        mem_rd_valid && mem_rd_ready |=> !mem_rd_valid);

    // response fields stay put while the consumer stalls
    assert_rsp_hold_R9: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_entry)
                                    && $stable(rsp_level) && $stable(rsp_fault));

    // idle again right after the response is taken
    assert_rsp_to_idle_R9: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && rsp_ready |=> req_ready);

    // a successful walk ends on a final entry at level 1..3
    assert_leaf_ok_R4: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && !rsp_fault |-> rsp_level != 2'd0 && rsp_entry[1:0] == 2'b10);

    // a pointer can only be the fault cause at the last level
    assert_ptr_fault_R7: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && rsp_fault && rsp_entry[1:0] == 2'b01 |-> rsp_level == 2'd3);

    // no request accepted while busy
    assert_busy_R10: assert property (@(posedge clk) disable iff (rst)
        mem_rd_valid || mem_rsp_ready || rsp_valid |-> !req_ready);
endmodule

// File: tb/ptw_walker_bench.sv
module ptw_walker_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_root_we = 1'b0;
    logic [31:0] cfg_root_data = '0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic [15:0] req_ctx = '0;
    logic        mem_rd_valid;
    logic        mem_rd_ready = 1'b0;
    logic [35:0] mem_rd_addr;
    logic        mem_rsp_valid = 1'b0;
    logic        mem_rsp_ready;
    logic [31:0] mem_rsp_data = '0;
    logic        rsp_valid;
    logic        rsp_ready = 1'b0;
    logic [31:0] rsp_entry;
    logic [1:0]  rsp_level;
    logic        rsp_fault;

    always #10 clk = ~clk;

    ptw_walker u_ptw_walker (.*);

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [31:0] mem_q [logic [35:0]];
    logic [31:0] root_val = '0;
    logic [35:0] rd_log [8];
    int          rd_cnt = 0;
    logic [35:0] exp_addr [4];
    int          exp_n;
    logic [31:0] exp_entry;
    logic [1:0]  exp_level;
    logic        exp_fault;

    task automatic check(input bit ok, input string tag, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mem_rd(input logic [35:0] a);
        return mem_q.exists(a) ? mem_q[a] : 32'h0;
    endfunction

    function automatic logic [35:0] expand(input logic [31:0] w);
        return {w[31:4], 8'h00};
    endfunction

    function automatic logic [35:0] idx_of(input int l, input logic [31:0] va,
                                           input logic [15:0] ctx);
        case (l)
            0: return 36'(ctx);
            1: return 36'(va[31:24]);
            2: return 36'(va[23:18]);
            default: return 36'(va[17:12]);
        endcase
    endfunction

    // reference walk over the bench memory
    task automatic ref_walk(input logic [31:0] va, input logic [15:0] ctx);
        logic [35:0] a;
        logic [31:0] w;
        a = expand(root_val) + (idx_of(0, va, ctx) << 2);
        for (int l = 0; l < 4; l++) begin
            exp_addr[l] = a;
            exp_n = l + 1;
            w = mem_rd(a);
            exp_entry = w;
            exp_level = 2'(l);
            if (w[1:0] == 2'd2) begin
                exp_fault = (l == 0);
                return;
            end else if (w[1:0] == 2'd1 && l < 3) begin
                a = expand(w) + (idx_of(l + 1, va, ctx) << 2);
            end else begin
                exp_fault = 1'b1;
                return;
            end
        end
    endtask

    // build a pointer chain to depth and place final_word there
    task automatic build(input logic [31:0] va, input logic [15:0] ctx,
                         input int depth, input logic [31:0] final_word);
        logic [35:0] a;
        logic [31:0] w;
        a = expand(root_val) + (idx_of(0, va, ctx) << 2);
        for (int l = 0; l < depth; l++) begin
            w = $urandom;
            w[1:0] = 2'b01;
            mem_q[a] = w;
            a = expand(w) + (idx_of(l + 1, va, ctx) << 2);
        end
        mem_q[a] = final_word;
    endtask

    task automatic set_root(input logic [31:0] v);
        @(negedge clk);
        cfg_root_we = 1'b1;
        cfg_root_data = v;
        @(negedge clk);
        cfg_root_we = 1'b0;
        root_val = v;
    endtask

    // memory responder with random stalls
    initial begin
        logic [35:0] cap;
        logic [35:0] prev_addr;
        bit          stalled;
        stalled = 0;
        prev_addr = '0;
        forever begin
            @(negedge clk);
            if (stalled) begin
                check(mem_rd_valid && mem_rd_addr == prev_addr, "R8 read held",
                      64'(mem_rd_addr), 64'(prev_addr));
                stalled = 0;
            end
            if (mem_rd_valid && !rst) begin
                if ($urandom % 3 != 0) begin
                    cap = mem_rd_addr;
                    if (rd_cnt < 8) rd_log[rd_cnt] = cap;
                    rd_cnt++;
                    mem_rd_ready = 1'b1;
                    @(negedge clk);
                    mem_rd_ready = 1'b0;
                    repeat ($urandom % 3) begin
                        check(!mem_rd_valid, "R8 no second read", 64'(mem_rd_valid), 64'd0);
                        @(negedge clk);
                    end
                    check(!mem_rd_valid && mem_rsp_ready, "R8 waiting for data",
                          64'({mem_rd_valid, mem_rsp_ready}), 64'b01);
                    mem_rsp_data = mem_rd(cap);
                    mem_rsp_valid = 1'b1;
                    @(negedge clk);
                    mem_rsp_valid = 1'b0;
                    mem_rsp_data = $urandom;
                end else begin
                    prev_addr = mem_rd_addr;
                    stalled = 1;
                end
            end
        end
    end

    task automatic run_walk(input logic [31:0] va, input logic [15:0] ctx,
                            input string tag);
        int wait_cnt;
        logic [31:0] e0;
        logic [1:0]  l0;
        logic        f0;
        ref_walk(va, ctx);
        rd_cnt = 0;
        @(negedge clk);
        req_valid = 1'b1;
        req_vaddr = va;
        req_ctx = ctx;
        @(negedge clk);
        // R10: a request while busy is ignored
        req_vaddr = ~va;
        req_ctx = ~ctx;
        check(!req_ready, "R10 busy", 64'(req_ready), 64'd0);
        @(negedge clk);
        req_valid = 1'b0;
        wait_cnt = 0;
        while (!rsp_valid && wait_cnt < 200) begin
            @(negedge clk);
            wait_cnt++;
        end
        check(rd_cnt == exp_n, {tag, " R3 read count"}, 64'(rd_cnt), 64'(exp_n));
        for (int i = 0; i < exp_n && i < rd_cnt; i++)
            check(rd_log[i] == exp_addr[i], {tag, i == 0 ? " R2 ctx addr" : " R3 level addr"},
                  64'(rd_log[i]), 64'(exp_addr[i]));
        check(rsp_valid && rsp_entry == exp_entry && rsp_level == exp_level &&
              rsp_fault == exp_fault, tag,
              {27'd0, rsp_valid, rsp_entry, rsp_level, rsp_fault, 1'b0},
              {27'd0, 1'b1, exp_entry, exp_level, exp_fault, 1'b0});
        e0 = rsp_entry; l0 = rsp_level; f0 = rsp_fault;
        repeat (1 + $urandom % 2) @(negedge clk);
        check(rsp_valid && rsp_entry == e0 && rsp_level == l0 && rsp_fault == f0,
              "R9 response held", {29'd0, rsp_valid, rsp_entry, rsp_level, rsp_fault},
              {29'd0, 1'b1, e0, l0, f0});
        rsp_ready = 1'b1;
        @(negedge clk);
        rsp_ready = 1'b0;
        check(req_ready && !rsp_valid, "R9 back to idle", 64'({req_ready, rsp_valid}),
              64'b10);
    endtask

    initial begin
        logic [31:0] va;
        logic [15:0] ctx;
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(req_ready && !mem_rd_valid && !rsp_valid, "R1 reset state",
              64'({req_ready, mem_rd_valid, rsp_valid}), 64'b100);
        rst = 1'b0;

        // directed: leaves at each level (R4)
        set_root(32'h0012_3450);
        va = 32'hA5C3_7123; ctx = 16'h0007;
        mem_q.delete(); build(va, ctx, 1, 32'hCAFE_01AE); run_walk(va, ctx, "R4 leaf level1");
        mem_q.delete(); build(va, ctx, 2, 32'h1234_56F2); run_walk(va, ctx, "R4 leaf level2");
        mem_q.delete(); build(va, ctx, 3, 32'hFFFF_FF02); run_walk(va, ctx, "R4 leaf level3");
        // R5: invalid at context and at level 2
        mem_q.delete(); build(va, ctx, 0, 32'h0000_0000); run_walk(va, ctx, "R5 invalid ctx");
        mem_q.delete(); build(va, ctx, 2, 32'h8765_4320); run_walk(va, ctx, "R5 invalid level2");
        // R6: reserved type
        mem_q.delete(); build(va, ctx, 2, 32'h0000_1233); run_walk(va, ctx, "R6 reserved level2");
        mem_q.delete(); build(va, ctx, 0, 32'h4444_4443); run_walk(va, ctx, "R6 reserved ctx");
        // R7: pointer at level 3, leaf at context level
        mem_q.delete(); build(va, ctx, 3, 32'h5555_5551); run_walk(va, ctx, "R7 pointer level3");
        mem_q.delete(); build(va, ctx, 0, 32'h7777_7702); run_walk(va, ctx, "R7 leaf in ctx table");
        // R2: low root bits ignored, max context, index extremes
        set_root(32'hFFFF_FFFF);
        va = 32'hFFFF_F000; ctx = 16'hFFFF;
        mem_q.delete(); build(va, ctx, 3, 32'h0000_0102); run_walk(va, ctx, "R2 root low bits");
        va = 32'h0000_0FFF; ctx = 16'h0000;
        mem_q.delete(); build(va, ctx, 3, 32'h0000_0202); run_walk(va, ctx, "R3 zero indices");

        // random walks
        for (int t = 0; t < 300; t++) begin
            int depth;
            logic [31:0] fw;
            if (t % 25 == 0) set_root($urandom);
            va = $urandom;
            ctx = 16'($urandom);
            depth = $urandom % 4;
            fw = $urandom;
            if ($urandom % 4 != 0) fw[1:0] = 2'b10;
            mem_q.delete();
            build(va, ctx, depth, fw);
            run_walk(va, ctx, "R4 random walk");
        end

        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule